// File: doc/BRIEF.md
# Challenge-Response Page Responder

This block is the device side of an authenticated page read. A host presents a request that carries a page number, the page contents, a challenge and a challenge-length mode. The block takes that request together with the device's 64-bit secret and its 7-byte identifier. It captures everything into a 512-bit message block and streams back the 32 page bytes, one filler byte of 0xFF and the bit-inverted CRC-16 of the transaction. Only after the last CRC byte has been accepted does it run an 80-round SHA-1 compression over the captured block. It then streams the 20-byte result.

The result is the raw compression state. It is the SHA-1 round function applied to a single block, without the final addition of the initial chaining value. The host holds the same secret, computes the same value and compares the two. Both byte streams use a plain valid/ready handshake. A byte moves on a clock edge where both valid and ready are high.

The controller walks a fixed sequence of states. `ST_IDLE` moves to `ST_PAGE` when a request is accepted. `ST_PAGE` moves to `ST_FILL` after page byte 31 is accepted. `ST_FILL` moves to `ST_CRC_LO`, and `ST_CRC_LO` moves to `ST_CRC_HI`, each when its byte is accepted. `ST_CRC_HI` moves to `ST_HASH` when its byte is accepted, and that same edge loads the hash engine. `ST_HASH` moves to `ST_DIGEST` on the edge that completes round 79. `ST_DIGEST` returns to `ST_IDLE` after byte 19 is accepted.

Top module: `auth_page_responder`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` is 0 and `req_ready` is 1.
- R2: After a request is accepted, the first 32 output bytes are the page bytes P0..P31 in that order. Byte Pi is `page_data[8i+7:8i]`.
- R3: Output byte 32 (counting from 0) is always 0xFF.
- R4: Output bytes 33 and 34 are the low byte and then the high byte of the inverted CRC. The CRC is CRC-16 with polynomial x^16+x^15+x^2+1, processed LSB-first (reflected constant 0xA001), starting from 0x0000. It runs over the command byte `CMD_CODE`, the 16-bit address (page number × 32, low byte first) and P0..P31.
- R5: After byte 34 is accepted, `out_valid` stays 0 for exactly 80 clock cycles, and digest byte 0 is valid in the 81st cycle.
- R6: The digest is the 80-round SHA-1 compression state {A,B,C,D,E}, with no final addition, over 16 big-endian words. The words are: W0={k0,k1,k2,k3}; W1..W8=P0..P31, four per word, first byte most significant; W9={c0,c1,x0,x1}; W10={M,id0,id1,id2}; W11={id3..id6}; W12={k4..k7}; W13={c2,c3,c4,x2}; W14={x3..x6}; W15={x7..x10}. Here ki=`secret[8i+7:8i]`, idi=`uid[8i+7:8i]`, ci=`challenge[8i+7:8i]` and xi=`XCONST[8i+7:8i]`.
- R7: When `short_chal` is 1, c0 and c1 are replaced by 0xFF, so `challenge[15:0]` has no effect on the digest.
- R8: The 20 digest bytes leave as E bits 7:0 first, rising through E, then D, C, B and A, ending with A bits 31:24. The transaction is then complete and `req_ready` returns to 1.
- R9: M = `M_BASE` | (page number << `M_SHIFT`), truncated to 8 bits.
- R10: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_data` unchanged.
- R11: `req_ready` is 0 from acceptance until the last digest byte leaves. A request raised in that time has no effect on any output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| secret | input | 64 | Device secret, k0 in bits 7:0 |
| uid | input | 56 | Unique identifier, id0 in bits 7:0 |
| page_data | input | 256 | Page contents, P0 in bits 7:0 |
| challenge | input | 40 | Challenge bytes, c0 in bits 7:0 |
| short_chal | input | 1 | 1 selects 3-byte challenge mode |
| page_num | input | PAGE_W (2) | Addressed page number |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Output byte |

## Verification
A corrupted captured block or a wrong byte index shows in the page bytes within a cycle of acceptance, and a wrong CRC state shows at byte 33. Any slip in the message layout, the round constants, the schedule or the round count changes almost every digest byte. The round count also moves the first digest byte away from its fixed 80-cycle slot. A state machine that leaves the sequence shows up as a wrong stream length, a stall that drops a byte, or `req_ready` rising before the last digest byte.

// File: rtl/auth_resp_pkg.sv
package auth_resp_pkg;

    localparam int SHA_WORDS    = 16;
    localparam int SHA_ROUNDS   = 80;
    localparam int BLOCK_BITS   = 32 * SHA_WORDS;
    localparam int PAGE_BYTES   = 32;
    localparam int DIGEST_BYTES = 20;
    localparam int XCONST_BYTES = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_FILL,
        ST_CRC_LO,
        ST_CRC_HI,
        ST_HASH,
        ST_DIGEST
    } resp_state_e;

    // Reflected CRC-16 (x^16+x^15+x^2+1), one byte, LSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] r;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ din[i]) r = (r >> 1) ^ 16'hA001;
            else               r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/auth_block_builder.sv
module auth_block_builder
    import auth_resp_pkg::*;
#(
    parameter int                        PAGE_W  = 2,
    parameter logic [8*XCONST_BYTES-1:0] XCONST  = 88'h5A_A5_3C_C3_0F_F0_96_69_11_22_33,
    parameter logic [7:0]                M_BASE  = 8'h0C,
    parameter int                        M_SHIFT = 5
) (
    input  logic [63:0]             secret,
    input  logic [55:0]             uid,
    input  logic [8*PAGE_BYTES-1:0] page_data,
    input  logic [39:0]             challenge,
    input  logic                    short_chal,
    input  logic [PAGE_W-1:0]       page_num,
    output logic [BLOCK_BITS-1:0]   block
);

    localparam int PAGE_TOP = BLOCK_BITS - 33;   // MSB of word 1

    logic [7:0] ch0, ch1, mval;

    function automatic logic [7:0] xb(input int idx);
        return XCONST[8*idx +: 8];
    endfunction

    assign ch0  = short_chal ? 8'hFF : challenge[7:0];
    assign ch1  = short_chal ? 8'hFF : challenge[15:8];
    assign mval = M_BASE | 8'(8'(page_num) << M_SHIFT);

    // word 0: first half of the secret
    assign block[511:480] = {secret[7:0], secret[15:8], secret[23:16], secret[31:24]};

    // words 1..8: page bytes, first byte most significant
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_page
        assign block[PAGE_TOP - 8*g -: 8] = page_data[8*g +: 8];
    end

    assign block[223:192] = {ch0, ch1, xb(0), xb(1)};
    assign block[191:160] = {mval, uid[7:0], uid[15:8], uid[23:16]};
    assign block[159:128] = {uid[31:24], uid[39:32], uid[47:40], uid[55:48]};
    assign block[127:96]  = {secret[39:32], secret[47:40], secret[55:48], secret[63:56]};
    assign block[95:64]   = {challenge[23:16], challenge[31:24], challenge[39:32], xb(2)};
    assign block[63:32]   = {xb(3), xb(4), xb(5), xb(6)};
    assign block[31:0]    = {xb(7), xb(8), xb(9), xb(10)};

endmodule

// File: rtl/auth_crc16_acc.sv
module auth_crc16_acc
    import auth_resp_pkg::*;
#(
    parameter logic [7:0] CMD_CODE = 8'hA5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] addr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 16'h0000;
        end else if (start) begin
            crc <= crc16_step(crc16_step(crc16_step(16'h0000, CMD_CODE), addr[7:0]), addr[15:8]);
        end else if (upd) begin
            crc <= crc16_step(crc, din);
        end
    end

endmodule

// File: rtl/auth_sha1_core.sv
module auth_sha1_core
    import auth_resp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [BLOCK_BITS-1:0] block,
    output logic                  busy,
    output logic                  last,
    output logic [159:0]          digest
);

    localparam int RND_W = $clog2(SHA_ROUNDS);

    logic [31:0]      w [SHA_WORDS];
    logic [31:0]      ra, rb, rc, rd, re;
    logic [RND_W-1:0] rnd;
    logic [31:0]      fval, kval, tmp, wnew, wmix;

    always_comb begin
        if (rnd < RND_W'(20)) begin
            fval = (rb & rc) | (~rb & rd);
            kval = 32'h5A827999;
        end else if (rnd < RND_W'(40)) begin
            fval = rb ^ rc ^ rd;
            kval = 32'h6ED9EBA1;
        end else if (rnd < RND_W'(60)) begin
            fval = (rb & rc) | (rb & rd) | (rc & rd);
            kval = 32'h8F1BBCDC;
        end else begin
            fval = rb ^ rc ^ rd;
            kval = 32'hCA62C1D6;
        end
        tmp  = {ra[26:0], ra[31:27]} + fval + re + kval + w[0];
        wmix = w[13] ^ w[8] ^ w[2] ^ w[0];
        wnew = {wmix[30:0], wmix[31]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            rnd  <= '0;
            ra   <= '0;
            rb   <= '0;
            rc   <= '0;
            rd   <= '0;
            re   <= '0;
            for (int i = 0; i < SHA_WORDS; i++) w[i] <= '0;
        end else if (load) begin
            busy <= 1'b1;
            rnd  <= '0;
            ra   <= 32'h67452301;
            rb   <= 32'hEFCDAB89;
            rc   <= 32'h98BADCFE;
            rd   <= 32'h10325476;
            re   <= 32'hC3D2E1F0;
            for (int i = 0; i < SHA_WORDS; i++) w[i] <= block[BLOCK_BITS-1-32*i -: 32];
        end else if (busy) begin
            ra <= tmp;
            rb <= ra;
            rc <= {rb[1:0], rb[31:2]};
            rd <= rc;
            re <= rd;
            for (int i = 0; i < SHA_WORDS-1; i++) w[i] <= w[i+1];
            w[SHA_WORDS-1] <= wnew;
            rnd <= rnd + 1'b1;
            if (rnd == RND_W'(SHA_ROUNDS-1)) busy <= 1'b0;
        end
    end

    assign last   = busy && (rnd == RND_W'(SHA_ROUNDS-1));
    assign digest = {ra, rb, rc, rd, re};

endmodule

// File: rtl/auth_page_responder.sv
module auth_page_responder
    import auth_resp_pkg::*;
#(
    parameter int                        PAGE_W   = 2,
    parameter logic [7:0]                CMD_CODE = 8'hA5,
    parameter logic [7:0]                M_BASE   = 8'h0C,
    parameter int                        M_SHIFT  = 5,
    parameter logic [8*XCONST_BYTES-1:0] XCONST   = 88'h5A_A5_3C_C3_0F_F0_96_69_11_22_33
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [63:0]             secret,
    input  logic [55:0]             uid,
    input  logic [8*PAGE_BYTES-1:0] page_data,
    input  logic [39:0]             challenge,
    input  logic                    short_chal,
    input  logic [PAGE_W-1:0]       page_num,
    input  logic                    req_valid,
    output logic                    req_ready,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [7:0]              out_data
);

    localparam int IDX_W    = $clog2(PAGE_BYTES);
    localparam int PAGE_TOP = BLOCK_BITS - 33;

    resp_state_e             state, state_nxt;
    logic [IDX_W-1:0]        idx;
    logic [BLOCK_BITS-1:0]   blk_in, blk_q;
    logic [15:0]             crc, addr;
    logic [159:0]            digest;
    logic                    core_busy, core_last, core_load;
    logic                    req_fire, out_fire, page_end, dig_end;
    logic [8:0]              pg_bit;
    logic [7:0]              dg_bit;

    assign req_fire  = req_valid && req_ready;
    assign out_fire  = out_valid && out_ready;
    assign page_end  = idx == IDX_W'(PAGE_BYTES-1);
    assign dig_end   = idx == IDX_W'(DIGEST_BYTES-1);
    assign core_load = (state == ST_CRC_HI) && out_fire;
    assign addr      = 16'(32'(page_num) * PAGE_BYTES);

    auth_block_builder #(
        .PAGE_W (PAGE_W),
        .XCONST (XCONST),
        .M_BASE (M_BASE),
        .M_SHIFT(M_SHIFT)
    ) u_build (
        .secret    (secret),
        .uid       (uid),
        .page_data (page_data),
        .challenge (challenge),
        .short_chal(short_chal),
        .page_num  (page_num),
        .block     (blk_in)
    );

    auth_crc16_acc #(.CMD_CODE(CMD_CODE)) u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .start(req_fire),
        .addr (addr),
        .upd  ((state == ST_PAGE) && out_fire),
        .din  (out_data),
        .crc  (crc)
    );

    auth_sha1_core u_sha (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (core_load),
        .block (blk_q),
        .busy  (core_busy),
        .last  (core_last),
        .digest(digest)
    );

    // state register, byte index and captured block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            blk_q <= '0;
        end else begin
            state <= state_nxt;
            if (req_fire) begin
                blk_q <= blk_in;
                idx   <= '0;
            end else if (out_fire && (state == ST_PAGE)) begin
                idx <= page_end ? '0 : idx + 1'b1;
            end else if (out_fire && (state == ST_DIGEST)) begin
                idx <= dig_end ? '0 : idx + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (req_fire)             state_nxt = ST_PAGE;
            ST_PAGE:   if (out_fire && page_end) state_nxt = ST_FILL;
            ST_FILL:   if (out_fire)             state_nxt = ST_CRC_LO;
            ST_CRC_LO: if (out_fire)             state_nxt = ST_CRC_HI;
            ST_CRC_HI: if (out_fire)             state_nxt = ST_HASH;
            ST_HASH:   if (core_last)            state_nxt = ST_DIGEST;
            ST_DIGEST: if (out_fire && dig_end)  state_nxt = ST_IDLE;
            default:                             state_nxt = ST_IDLE;
        endcase
    end

    assign pg_bit = 9'(PAGE_TOP) - {1'b0, idx, 3'b000};
    assign dg_bit = {idx, 3'b000};

    // outputs
    always_comb begin
        req_ready = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_PAGE:   begin out_valid = 1'b1; out_data = blk_q[pg_bit -: 8]; end
            ST_FILL:   begin out_valid = 1'b1; out_data = 8'hFF;              end
            ST_CRC_LO: begin out_valid = 1'b1; out_data = ~crc[7:0];          end
            ST_CRC_HI: begin out_valid = 1'b1; out_data = ~crc[15:8];         end
            ST_HASH:   ;
            ST_DIGEST: begin out_valid = 1'b1; out_data = digest[dg_bit +: 8]; end
            default:   ;
        endcase
    end

endmodule

// File: rtl/auth_page_responder_chk.sv
module auth_page_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       core_busy
);

    logic [5:0] nbytes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      nbytes <= '0;
        else if (req_valid && req_ready) nbytes <= '0;
        else if (out_valid && out_ready) nbytes <= nbytes + 1'b1;
    end

    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && req_ready));

    assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nbytes == 6'd32) |-> (out_data == 8'hFF));

    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |-> !out_valid);

    assert_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && nbytes == 6'd54) |=> req_ready);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

endmodule

bind auth_page_responder auth_page_responder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .core_busy(core_busy)
);

// File: tb/auth_page_responder_bench.sv
`timescale 1ns/1ps
module auth_page_responder_bench;

    localparam int          PW      = 2;
    localparam logic [7:0]  CMD     = 8'hA5;
    localparam logic [7:0]  MBASE   = 8'h0C;
    localparam int          MSHIFT  = 5;
    localparam logic [87:0] XC      = 88'h5A_A5_3C_C3_0F_F0_96_69_11_22_33;
    localparam int          NBYTES  = 55;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [63:0]   secret = '0;
    logic [55:0]   uid = '0;
    logic [255:0]  page_data = '0;
    logic [39:0]   challenge = '0;
    logic          short_chal = 1'b0;
    logic [PW-1:0] page_num = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    auth_page_responder u_auth_page_responder (
        .clk(clk), .rst_n(rst_n), .secret(secret), .uid(uid),
        .page_data(page_data), .challenge(challenge), .short_chal(short_chal),
        .page_num(page_num), .req_valid(req_valid), .req_ready(req_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            logic fb;
            fb = r[0] ^ d[b];
            r  = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] sha_ref(input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {a, b, c, d, e};
    endfunction

    function automatic logic [511:0] blk_ref(input logic [63:0] k, input logic [55:0] id,
                                             input logic [255:0] pg, input logic [39:0] ch,
                                             input bit sh, input logic [PW-1:0] pn);
        logic [7:0]   by [64];
        logic [511:0] r;
        logic [7:0]   m;
        m = MBASE | 8'(8'(pn) << MSHIFT);
        for (int i = 0; i < 4; i++)  by[i]      = k[8*i +: 8];
        for (int i = 0; i < 32; i++) by[4+i]    = pg[8*i +: 8];
        by[36] = sh ? 8'hFF : ch[7:0];
        by[37] = sh ? 8'hFF : ch[15:8];
        by[38] = XC[7:0];
        by[39] = XC[15:8];
        by[40] = m;
        for (int i = 0; i < 7; i++)  by[41+i]   = id[8*i +: 8];
        for (int i = 0; i < 4; i++)  by[48+i]   = k[32+8*i +: 8];
        for (int i = 0; i < 3; i++)  by[52+i]   = ch[16+8*i +: 8];
        by[55] = XC[23:16];
        for (int i = 0; i < 8; i++)  by[56+i]   = XC[24+8*i +: 8];
        for (int j = 0; j < 64; j++) r[511-8*j -: 8] = by[j];
        return r;
    endfunction

    task automatic run_txn(input logic [PW-1:0] pn, input logic [39:0] ch, input bit sh,
                           input logic [255:0] pg, input int stall_mod,
                           output logic [159:0] dg_out);
        logic [7:0]   got_b [NBYTES];
        int           got, gap, guard;
        bit           pv, pf;
        logic [7:0]   pd;
        logic [255:0] pg_got;
        logic [15:0]  crc_e, addr;
        logic [159:0] dg_got, dg_exp;

        @(negedge clk);
        chk("R11 idle ready", {255'd0, req_ready}, 256'd1);
        page_num = pn; challenge = ch; short_chal = sh; page_data = pg;
        req_valid = 1'b1;
        out_ready = 1'b0;
        dg_exp = sha_ref(blk_ref(secret, uid, pg, ch, sh, pn));
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; gap = 0; guard = 0; pv = 1'b0; pf = 1'b0; pd = '0;
        while (got < NBYTES && guard < 5000) begin
            guard++;
            out_ready = (($urandom % stall_mod) != 0);
            if (got < 50 && ($urandom % 6) == 0) begin
                req_valid = 1'b1;
                challenge = $urandom;
                page_num  = PW'($urandom);
                chk("R11 busy ready", {255'd0, req_ready}, 256'd0);
            end else begin
                req_valid = 1'b0;
            end
            if (out_valid) begin
                if (pv && !pf) chk("R10 stall hold", {248'd0, out_data}, {248'd0, pd});
                if (out_ready) begin
                    got_b[got] = out_data;
                    got++;
                end
            end else if (got == 35) begin
                gap++;
            end
            pv = out_valid; pf = out_valid && out_ready; pd = out_data;
            @(negedge clk);
        end
        req_valid = 1'b0;
        out_ready = 1'b0;
        chk("R8 stream complete", 256'(got), 256'(NBYTES));
        chk("R8 R11 ready after digest", {255'd0, req_ready}, 256'd1);

        for (int i = 0; i < 32; i++) pg_got[8*i +: 8] = got_b[i];
        chk("R2 page bytes", pg_got, pg);
        chk("R3 filler", {248'd0, got_b[32]}, 256'h0FF);

        addr  = 16'(32'(pn) * 32);
        crc_e = crc_ref(16'h0000, CMD);
        crc_e = crc_ref(crc_e, addr[7:0]);
        crc_e = crc_ref(crc_e, addr[15:8]);
        for (int i = 0; i < 32; i++) crc_e = crc_ref(crc_e, pg[8*i +: 8]);
        chk("R4 crc", {240'd0, got_b[34], got_b[33]}, {240'd0, ~crc_e});

        chk("R5 hash gap", 256'(gap), 256'd80);

        for (int j = 0; j < 20; j++) dg_got[8*j +: 8] = got_b[35+j];
        chk(sh ? "R6 R7 R8 R9 digest" : "R6 R8 R9 digest", {96'd0, dg_got}, {96'd0, dg_exp});
        dg_out = dg_got;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [159:0] d1, d2, dn;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {255'd0, out_valid}, 256'd0);
        chk("R1 reset ready", {255'd0, req_ready}, 256'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset valid", {255'd0, out_valid}, 256'd0);

        // directed: zero page, page 0, long challenge, no stalls
        secret = 64'h0123456789ABCDEF; uid = 56'h11223344556677;
        run_txn(2'd0, 40'h0, 1'b0, 256'd0, 1000000, dn);
        // directed: all-ones page, last page, heavy stalls
        run_txn(2'd3, 40'hFFFFFFFFFF, 1'b0, {256{1'b1}}, 2, dn);
        // short mode: low challenge bytes must not matter (R7)
        run_txn(2'd1, 40'hC4C3C2_1234, 1'b1, {8{32'hDEADBEEF}}, 3, d1);
        run_txn(2'd1, 40'hC4C3C2_ABCD, 1'b1, {8{32'hDEADBEEF}}, 4, d2);
        chk("R7 short mode ignores c0 c1", {96'd0, d1}, {96'd0, d2});
        // long mode: same change must matter
        run_txn(2'd1, 40'hC4C3C2_1234, 1'b0, {8{32'hDEADBEEF}}, 3, d1);
        run_txn(2'd1, 40'hC4C3C2_ABCD, 1'b0, {8{32'hDEADBEEF}}, 3, d2);
        chk("R6 long mode uses c0 c1", {255'd0, (d1 != d2)}, 256'd1);

        // constrained random
        for (int n = 0; n < 10; n++) begin
            logic [255:0] pg;
            for (int i = 0; i < 8; i++) pg[32*i +: 32] = $urandom;
            secret = {$urandom, $urandom};
            uid    = 56'({$urandom, $urandom});
            run_txn(PW'($urandom), {8'($urandom), $urandom}, bit'($urandom % 2), pg,
                    2 + ($urandom % 4), dn);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule